// File: doc/BRIEF.md
# Decade-Switchable Square Wave Generator

This block makes a square wave from a fast system clock. A prescaler divides the system clock into a counting tick. A down counter runs through a programmable period on that tick. The output is high while the count is below a compare value. The compare value is always half the period, so the duty cycle stays at 50 %.

Two pulse inputs move the period along a logarithmic table of `TBL_LEN` entries, spaced at ten entries per decade. The table is computed when the block is elaborated from `PERIOD_MAX`. A third pulse input switches the prescaler between two ratios. With the default ratios of 4 and 40, this moves the whole frequency span down by one decade or back again. An active-low freeze input stops the counter and the prescaler directly in hardware.

The block reports the selected period and range to display logic, along with a one-cycle `changed_o` pulse on every real change. It never applies a new period or ratio in the middle of a wave cycle. A new setting waits in a shadow copy until the counter reaches its terminal count.

With the defaults, a 24 MHz system clock and a ratio of 4 give a 6 MHz tick. Reset selects table index 10, a period of 6000, so the output is 1 kHz. Stepping across the table covers 100 Hz to 10 kHz. The slow range covers 10 Hz to 1 kHz.

The run controller has three named states:
- **LIVE**: the counter runs and the applied setting equals the selected one.
- **ARMED**: the counter runs and a new setting is waiting for the terminal count.
- **HALTED**: the counter and the prescaler hold.

The controller moves between these states as follows:
- **freeze**: from LIVE or ARMED to HALTED, when `freeze_n` is low.
- **request**: from LIVE to ARMED, when the selection differs from the applied setting.
- **apply**: from ARMED to LIVE, when the setting has been loaded at the terminal count.
- **resume**: from HALTED to LIVE or ARMED, when `freeze_n` returns high; the target is ARMED if a setting is still waiting.

Top module: `sqw_gen`

## Requirements
- R1: After reset, `period_o` is the table entry at index `RESET_IDX` (6000 with the defaults). `range_o` is 0, `changed_o` is 0 and `wave_o` is 0. The first wave cycle then has high and low times of half a period each.
- R2: The wave is low for `period − period/2` ticks and then high for `period/2` ticks, where `/` rounds down. The high phase is the span in which the count is below the compare value.
- R3: With `range_o` = 0, one tick lasts `DIV_FAST` clocks. With `range_o` = 1, one tick lasts `DIV_SLOW` clocks.
- R4: Table entry i is round(`PERIOD_MAX` · 10^(−i/10)). A pulse on `step_up` moves to the next higher index, which is a shorter period. A pulse on `step_dn` moves to the next lower index.
- R5: Steps saturate at index 0 and index `TBL_LEN`−1. A step past either end changes nothing and gives no `changed_o` pulse.
- R6: A cycle with `step_up` and `step_dn` both high is ignored for the period.
- R7: A pulse on `range_tgl` inverts `range_o`. It may be combined with a step in the same cycle.
- R8: `period_o` and `range_o` show a new selection in the cycle after the clock edge that samples the input pulse. `changed_o` is high in that same cycle, and only when the period or the range actually changed.
- R9: A new period, compare value or ratio takes effect only at the counter's terminal count. The wave phase in progress keeps its old length.
- R10: While `freeze_n` is low, the counter and the prescaler hold. Both the halt and the restart take effect one clock after the edge of `freeze_n`. A freeze lasting H clocks therefore lengthens the current phase by exactly H clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| freeze_n | input | 1 | Low holds the counter and the prescaler |
| step_up | input | 1 | One-cycle pulse: raise the frequency by one table step |
| step_dn | input | 1 | One-cycle pulse: lower the frequency by one table step |
| range_tgl | input | 1 | One-cycle pulse: swap the prescaler ratio |
| wave_o | output | 1 | Square wave output |
| period_o | output | CNT_W | Selected period in ticks |
| range_o | output | 1 | Selected range: 0 = fast ratio, 1 = slow ratio |
| changed_o | output | 1 | One-cycle pulse when the period or the range changed |

## Verification
The selection results (`period_o`, `range_o` and `changed_o`) are due one clock after the edge that samples a pulse. The bench drives each pulse at a falling edge and reads the results at the next falling edge. It then reads `changed_o` once more one clock later to confirm that it has dropped.

Wave timing results are due only after a terminal count. After every change, the bench therefore waits for two falling edges of the wave before it counts clocks in a high phase and in a low phase. The mid-phase step and freeze tests instead count the phase that is in progress. They compare it with the old length, or with the old length plus the freeze time.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

    // Run controller states
    typedef enum logic [1:0] {
        ST_LIVE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_HALTED  = 2'd2
    } run_state_t;

    // Logarithmic period table entry: round(pmax * 10^(-idx/per_dec))
    function automatic int unsigned log_period(input int unsigned pmax,
                                               input int unsigned idx,
                                               input int unsigned per_dec);
        real scale;
        scale = $pow(10.0, -(real'(idx)) / real'(per_dec));
        return int'($rtoi(real'(pmax) * scale + 0.5));
    endfunction

endpackage

// File: rtl/sqw_prescaler.sv
module sqw_prescaler #(
    parameter int unsigned DIV_FAST = 4,
    parameter int unsigned DIV_SLOW = 40,
    localparam int unsigned DIV_MAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW,
    localparam int unsigned PRE_W   = (DIV_MAX < 2) ? 1 : $clog2(DIV_MAX)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow,
    output logic tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;

    // Last count value of the active ratio
    always_comb begin
        if (slow) lim = PRE_W'(DIV_SLOW - 1);
        else      lim = PRE_W'(DIV_FAST - 1);
    end

    assign tick = run && (pre_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (run) begin
            if (pre_q >= lim) pre_q <= '0;
            else              pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/sqw_step_ctrl.sv
module sqw_step_ctrl #(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned PERIOD_MAX  = 60000,
    parameter int unsigned TBL_LEN     = 21,
    parameter int unsigned PER_DECADE  = 10,
    parameter int unsigned RESET_IDX   = 10,
    localparam int unsigned IDX_W      = (TBL_LEN < 2) ? 1 : $clog2(TBL_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_up,
    input  logic             step_dn,
    input  logic             range_tgl,
    output logic [CNT_W-1:0] sel_period,
    output logic             sel_range,
    output logic             changed
);

    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(TBL_LEN - 1);

    logic [CNT_W-1:0] tbl [TBL_LEN];

    // Period table computed at elaboration
    for (genvar g = 0; g < TBL_LEN; g++) begin : g_tbl
        localparam int unsigned ENTRY = sqw_pkg::log_period(PERIOD_MAX, g, PER_DECADE);
        assign tbl[g] = CNT_W'(ENTRY);
    end

    logic [IDX_W-1:0] idx_q, idx_d;
    logic             rng_q, rng_d;
    logic             chg_q, chg_d;
    logic             up_ok, dn_ok;

    always_comb begin
        up_ok = step_up && !step_dn && (idx_q != IDX_TOP);
        dn_ok = step_dn && !step_up && (idx_q != '0);
        idx_d = idx_q;
        if (up_ok)      idx_d = idx_q + 1'b1;
        else if (dn_ok) idx_d = idx_q - 1'b1;
        rng_d = rng_q ^ range_tgl;
        chg_d = up_ok || dn_ok || range_tgl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= IDX_W'(RESET_IDX);
            rng_q <= 1'b0;
            chg_q <= 1'b0;
        end else begin
            idx_q <= idx_d;
            rng_q <= rng_d;
            chg_q <= chg_d;
        end
    end

    assign sel_period = tbl[idx_q];
    assign sel_range  = rng_q;
    assign changed    = chg_q;

endmodule

// File: rtl/sqw_counter.sv
module sqw_counter
    import sqw_pkg::*;
#(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned RST_PERIOD = 6000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] sel_period,
    input  logic             sel_range,
    output logic             run,
    output logic             act_range,
    output logic             wave,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] act_period_o,
    output run_state_t       state_o
);

    run_state_t       st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] cmp_q;
    logic             rng_q;
    logic             differ;
    logic             step_en;

    assign differ = (sel_period != per_q) || (sel_range != rng_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_LIVE;
        else        st_q <= st_d;
    end

    // Next-state decode
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LIVE: begin
                if (!freeze_n)   st_d = ST_HALTED;
                else if (differ) st_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!freeze_n)    st_d = ST_HALTED;
                else if (!differ) st_d = ST_LIVE;
            end
            ST_HALTED: begin
                if (freeze_n) st_d = differ ? ST_ARMED : ST_LIVE;
            end
            default: st_d = ST_LIVE;
        endcase
    end

    // Output decode
    always_comb begin
        unique case (st_q)
            ST_LIVE, ST_ARMED: run = 1'b1;
            ST_HALTED:         run = 1'b0;
            default:           run = 1'b0;
        endcase
    end

    assign step_en = run && tick;

    // Down counter with shadow load at terminal count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_PERIOD - 1);
            per_q <= CNT_W'(RST_PERIOD);
            cmp_q <= CNT_W'(RST_PERIOD / 2);
            rng_q <= 1'b0;
        end else if (step_en) begin
            if (cnt_q == '0) begin
                cnt_q <= sel_period - 1'b1;
                per_q <= sel_period;
                cmp_q <= sel_period >> 1;
                rng_q <= sel_range;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign wave         = (cnt_q < cmp_q);
    assign act_range    = rng_q;
    assign cnt_o        = cnt_q;
    assign act_period_o = per_q;
    assign state_o      = st_q;

endmodule

// File: rtl/sqw_gen.sv
module sqw_gen
    import sqw_pkg::*;
#(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned DIV_FAST   = 4,
    parameter int unsigned DIV_SLOW   = 40,
    parameter int unsigned PERIOD_MAX = 60000,
    parameter int unsigned TBL_LEN    = 21,
    parameter int unsigned PER_DECADE = 10,
    parameter int unsigned RESET_IDX  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze_n,
    input  logic             step_up,
    input  logic             step_dn,
    input  logic             range_tgl,
    output logic             wave_o,
    output logic [CNT_W-1:0] period_o,
    output logic             range_o,
    output logic             changed_o
);

    localparam int unsigned PERIOD_RST = log_period(PERIOD_MAX, RESET_IDX, PER_DECADE);
    localparam int unsigned PERIOD_MIN = log_period(PERIOD_MAX, TBL_LEN - 1, PER_DECADE);

    logic             tick;
    logic             run;
    logic             act_range;
    logic [CNT_W-1:0] sel_period;
    logic             sel_range;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] act_period_w;
    run_state_t       st_w;

    sqw_step_ctrl #(
        .CNT_W      (CNT_W),
        .PERIOD_MAX (PERIOD_MAX),
        .TBL_LEN    (TBL_LEN),
        .PER_DECADE (PER_DECADE),
        .RESET_IDX  (RESET_IDX)
    ) u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_up    (step_up),
        .step_dn    (step_dn),
        .range_tgl  (range_tgl),
        .sel_period (sel_period),
        .sel_range  (sel_range),
        .changed    (changed_o)
    );

    sqw_prescaler #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .slow  (act_range),
        .tick  (tick)
    );

    sqw_counter #(
        .CNT_W      (CNT_W),
        .RST_PERIOD (PERIOD_RST)
    ) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .freeze_n     (freeze_n),
        .tick         (tick),
        .sel_period   (sel_period),
        .sel_range    (sel_range),
        .run          (run),
        .act_range    (act_range),
        .wave         (wave_o),
        .cnt_o        (cnt_w),
        .act_period_o (act_period_w),
        .state_o      (st_w)
    );

    assign period_o = sel_period;
    assign range_o  = sel_range;

endmodule

// File: rtl/sqw_gen_chk.sv
module sqw_gen_chk
    import sqw_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned P_HI  = 60000,
    parameter int unsigned P_LO  = 600
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_up,
    input logic             step_dn,
    input logic             range_tgl,
    input logic             changed_o,
    input logic             range_o,
    input logic [CNT_W-1:0] period_o,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] act_period,
    input run_state_t       st
);

    assert_pulse_real_R8: assert property (@(posedge clk) disable iff (!rst_n)
        changed_o |-> ((period_o != $past(period_o)) || (range_o != $past(range_o))));

    assert_period_bounds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (period_o <= CNT_W'(P_HI)) && (period_o >= CNT_W'(P_LO)));

    assert_conflict_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && step_dn && !range_tgl) |=> !changed_o);

    assert_range_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        range_tgl |=> (range_o != $past(range_o)));

    assert_load_at_terminal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_period) |-> ($past(cnt_q) == '0));

    assert_frozen_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALTED) |=> $stable(cnt_q));

endmodule

bind sqw_gen sqw_gen_chk #(
    .CNT_W (CNT_W),
    .P_HI  (PERIOD_MAX),
    .P_LO  (PERIOD_MIN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_up    (step_up),
    .step_dn    (step_dn),
    .range_tgl  (range_tgl),
    .changed_o  (changed_o),
    .range_o    (range_o),
    .period_o   (period_o),
    .cnt_q      (cnt_w),
    .act_period (act_period_w),
    .st         (st_w)
);

// File: tb/sqw_gen_tb.sv
module sqw_gen_tb;

    localparam int DIV_A   = 2;
    localparam int DIV_B   = 20;
    localparam int WD_CYC  = 150000;

    // op codes: 0 up, 1 down, 2 toggle, 3 up+down, 4 up+toggle
    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] per;
        logic        rng;
        logic        chg;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 16'd48, 1'b0, 1'b1},   // R4 up
        '{3'd0, 16'd38, 1'b0, 1'b1},   // R4 up
        '{3'd1, 16'd48, 1'b0, 1'b1},   // R4 down
        '{3'd2, 16'd48, 1'b1, 1'b1},   // R7 toggle
        '{3'd1, 16'd60, 1'b1, 1'b1},   // R4 down in slow range
        '{3'd3, 16'd60, 1'b1, 1'b0},   // R6 conflict
        '{3'd4, 16'd48, 1'b0, 1'b1},   // R7 combined
        '{3'd0, 16'd38, 1'b0, 1'b1}    // R4 up
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        freeze_n = 1'b1;
    logic        step_up = 1'b0;
    logic        step_dn = 1'b0;
    logic        range_tgl = 1'b0;
    logic        wave_o;
    logic [15:0] period_o;
    logic        range_o;
    logic        changed_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sqw_gen #(
        .CNT_W      (16),
        .DIV_FAST   (DIV_A),
        .DIV_SLOW   (DIV_B),
        .PERIOD_MAX (600),
        .TBL_LEN    (21),
        .PER_DECADE (10),
        .RESET_IDX  (10)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .freeze_n  (freeze_n),
        .step_up   (step_up),
        .step_dn   (step_dn),
        .range_tgl (range_tgl),
        .wave_o    (wave_o),
        .period_o  (period_o),
        .range_o   (range_o),
        .changed_o (changed_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(input bit up, input bit dn, input bit tg);
        step_up = up; step_dn = dn; range_tgl = tg;
        @(negedge clk);
        step_up = 1'b0; step_dn = 1'b0; range_tgl = 1'b0;
    endtask

    task automatic measure(output int hi, output int lo);
        hi = 0; lo = 0;
        while (wave_o !== 1'b0) @(negedge clk);
        while (wave_o !== 1'b1) @(negedge clk);
        while (wave_o === 1'b1) begin hi++; @(negedge clk); end
        while (wave_o === 1'b0) begin lo++; @(negedge clk); end
    endtask

    task automatic settle();
        for (int k = 0; k < 2; k++) begin
            while (wave_o !== 1'b1) @(negedge clk);
            while (wave_o !== 1'b0) @(negedge clk);
        end
    endtask

    task automatic check_wave(input int per, input bit rng, input string req);
        int hi, lo, div;
        div = rng ? DIV_B : DIV_A;
        settle();
        measure(hi, lo);
        chk(hi == (per / 2) * div, {req, " high time"}, hi, (per / 2) * div);
        chk(lo == (per - per / 2) * div, {req, " low time"}, lo, (per - per / 2) * div);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", WD_CYC, 0);
        finish_run();
    end

    initial begin
        int hi, lo;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(period_o == 16'd60, "R1 reset period", period_o, 60);
        chk(range_o == 1'b0, "R1 reset range", range_o, 0);
        chk(changed_o == 1'b0, "R1 reset changed", changed_o, 0);
        chk(wave_o == 1'b0, "R1 reset wave", wave_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        measure(hi, lo);
        chk(hi == 60, "R1 R2 first high", hi, 60);
        chk(lo == 60, "R1 R2 first low", lo, 60);

        // Vector walk: R4 R6 R7 R8, then R2 R3 wave timing
        for (int v = 0; v < NV; v++) begin
            unique case (VECS[v].op)
                3'd0: pulse(1'b1, 1'b0, 1'b0);
                3'd1: pulse(1'b0, 1'b1, 1'b0);
                3'd2: pulse(1'b0, 1'b0, 1'b1);
                3'd3: pulse(1'b1, 1'b1, 1'b0);
                default: pulse(1'b1, 1'b0, 1'b1);
            endcase
            chk(period_o == VECS[v].per, "R4 R8 period", period_o, VECS[v].per);
            chk(range_o == VECS[v].rng, "R7 R8 range", range_o, VECS[v].rng);
            chk(changed_o == VECS[v].chg, "R8 changed pulse", changed_o, VECS[v].chg);
            @(negedge clk);
            chk(changed_o == 1'b0, "R8 pulse width", changed_o, 0);
            check_wave(VECS[v].per, VECS[v].rng, "R2 R3");
        end

        // R9: step in mid high phase; period 38 -> 48, range 0
        hi = 0; lo = 0;
        while (wave_o !== 1'b1) @(negedge clk);
        while (wave_o === 1'b1) begin
            hi++;
            step_dn = (hi == 4);
            @(negedge clk);
        end
        step_dn = 1'b0;
        while (wave_o === 1'b0) begin lo++; @(negedge clk); end
        chk(hi == 38, "R9 old high kept", hi, 38);
        chk(lo == 48, "R9 new low", lo, 48);
        chk(period_o == 16'd48, "R9 period", period_o, 48);

        // R10: freeze 50 clocks inside a high phase of period 48
        settle();
        hi = 0; lo = 0;
        while (wave_o !== 1'b1) @(negedge clk);
        while (wave_o === 1'b1) begin
            hi++;
            if (hi == 4)  freeze_n = 1'b0;
            if (hi == 54) freeze_n = 1'b1;
            @(negedge clk);
        end
        while (wave_o === 1'b0) begin lo++; @(negedge clk); end
        chk(hi == 48 + 50, "R10 frozen high", hi, 98);
        chk(lo == 48, "R10 low after resume", lo, 48);

        // R5 upper end: index 20, period 6
        for (int k = 0; k < 12; k++) pulse(1'b1, 1'b0, 1'b0);
        chk(period_o == 16'd6, "R5 top entry", period_o, 6);
        pulse(1'b1, 1'b0, 1'b0);
        chk(period_o == 16'd6, "R5 saturate top", period_o, 6);
        chk(changed_o == 1'b0, "R5 no pulse top", changed_o, 0);
        check_wave(6, 1'b0, "R5 R2");

        // R5 lower end: index 0, period 600
        for (int k = 0; k < 22; k++) pulse(1'b0, 1'b1, 1'b0);
        chk(period_o == 16'd600, "R5 bottom entry", period_o, 600);
        pulse(1'b0, 1'b1, 1'b0);
        chk(period_o == 16'd600, "R5 saturate bottom", period_o, 600);
        chk(changed_o == 1'b0, "R5 no pulse bottom", changed_o, 0);
        check_wave(600, 1'b0, "R5 R3");

        // R4 intermediate entries
        pulse(1'b1, 1'b0, 1'b0);
        chk(period_o == 16'd477, "R4 entry 1", period_o, 477);
        pulse(1'b1, 1'b0, 1'b0);
        chk(period_o == 16'd379, "R4 entry 2", period_o, 379);
        check_wave(379, 1'b0, "R4 R2 odd period");

        finish_run();
    end

endmodule